// File: doc/BRIEF.md
# Segment Register Descriptor Loader

This block holds a bank of segment registers, each paired with a hidden copy of its descriptor. When a register is loaded, the block splits the 16-bit selector into its fields and picks the global or local table base. It works out where the 8-byte descriptor lives, checks that address against the table's limit, and reads the descriptor through a 32-bit read port in two beats. It then unpacks the descriptor into base, limit, flags, type and privilege level and stores the result in that register's cache.

Once a register is loaded, address translation and field readout use only the cached copy and cause no memory reads. Loading the code segment register also updates the current privilege level. Faulting loads leave the register as it was. Two table base/limit pairs, one global and one local, are set through a simple write port.

Top module: `seg_loader`

## Requirements
- R1: A selector holds the descriptor index in bits 15:3, the table indicator in bit 2 (0 = global table, 1 = local table) and the requestor privilege level in bits 1:0. The descriptor address is the selected table base plus index*8. The first read beat fetches descriptor bits 31:0 at that address, and the second fetches bits 63:32 at the address plus 4.
- R2: Each read beat keeps `mem_req` high with a steady `mem_addr` until `mem_rvalid` is seen at a rising edge.
- R3: A stored descriptor is unpacked as follows. Base is {d[63:56], d[39:32], d[31:16]}. Limit is {d[51:48], d[15:0]}. Granularity is d[55], default size is d[54], available is d[52], system/normal is d[44], type is d[43:40] and privilege level is d[46:45]. These fields appear on the `rd_*` outputs for the register chosen by `rd_reg`.
- R4: If the present bit d[47] is 0, the load ends with `fault` high and `fault_code` 2, and the target register keeps its previous contents and valid state.
- R5: If index*8+7 exceeds the selected table's 16-bit limit, the load ends with `fault` high and `fault_code` 1, no read beat is issued, and the register is unchanged.
- R6: A successful load of register 1 (the code segment) sets `cpl` to the selector's bits 1:0. Loads of other registers, and faulting loads, leave `cpl` unchanged.
- R7: After reset, every register is invalid, `cpl` is 0 and the block is idle. Translating through an invalid register raises `tr_fault`.
- R8: `tr_lin` equals the cached base of register `tr_reg` plus `tr_off`, combinationally. No memory request is made while the block is idle.
- R9: `busy` is high from the cycle after an accepted `ld_req` through the cycle in which `done` pulses for exactly one cycle. A request made while busy, or one naming a register number of 6 or more, is ignored.
- R10: `tbl_we` writes `tbl_base` and `tbl_limit` into the global pair when `tbl_sel` is 0, and into the local pair when it is 1.
- R11: `rd_selector` returns the selector of the last successful load of the chosen register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table register write strobe |
| tbl_sel | input | 1 | 0 = global table pair, 1 = local table pair |
| tbl_base | input | 32 | Table base to write |
| tbl_limit | input | 16 | Table limit to write |
| ld_req | input | 1 | Load request |
| ld_reg | input | 3 | Segment register number to load |
| ld_sel | input | 16 | Selector to load |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle load completion pulse |
| fault | output | 1 | Completed load faulted (valid with done) |
| fault_code | output | 2 | 0 none, 1 table limit, 2 not present |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| rd_reg | input | 3 | Register chosen for readout |
| rd_valid | output | 1 | Chosen register holds a descriptor |
| rd_base | output | 32 | Cached base |
| rd_limit | output | 20 | Cached limit |
| rd_gran | output | 1 | Granularity flag |
| rd_db | output | 1 | Default size flag |
| rd_avl | output | 1 | Available flag |
| rd_sys | output | 1 | System/normal flag |
| rd_type | output | 4 | Segment type |
| rd_dpl | output | 2 | Descriptor privilege level |
| rd_selector | output | 16 | Cached selector |
| cpl | output | 2 | Current privilege level |
| tr_reg | input | 3 | Register used for translation |
| tr_off | input | 32 | Offset to translate |
| tr_lin | output | 32 | Linear address |
| tr_fault | output | 1 | Translation through an invalid register |

## Verification
The assertions assume that the read port answers each beat only while `mem_req` is high and that it returns one word per `mem_rvalid`. The bench's responder raises `mem_rvalid` only during an open request, after a random wait of zero to two cycles. The assertions also assume that reset is held for several cycles before the first load, which the bench does. The table registers are written only while the block is idle, so the limits that decide each load are known before the load starts.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int NUM_SEG = 6;
    localparam int CS_IDX  = 1;
    localparam int RW      = $clog2(NUM_SEG);
    localparam int AW      = 32;
    localparam int SW      = 16;
    localparam int LW      = 20;

    typedef struct packed {
        logic [AW-1:0] base;
        logic [LW-1:0] limit;
        logic          gran;
        logic          db;
        logic          avl;
        logic          sys;
        logic [3:0]    stype;
        logic [1:0]    dpl;
    } desc_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH_LO, ST_FETCH_HI, ST_CHECK, ST_DONE
    } ld_state_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0, FLT_LIMIT = 2'd1, FLT_ABSENT = 2'd2
    } flt_e;

    function automatic desc_t unpack_desc(input logic [63:0] d);
        desc_t r;
        r.base  = {d[63:56], d[39:32], d[31:16]};
        r.limit = {d[51:48], d[15:0]};
        r.gran  = d[55];
        r.db    = d[54];
        r.avl   = d[52];
        r.sys   = d[44];
        r.stype = d[43:40];
        r.dpl   = d[46:45];
        return r;
    endfunction
endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
    import seg_pkg::*;
(
    input  logic [SW-1:0] sel,
    input  logic [AW-1:0] gbase,
    input  logic [15:0]   glimit,
    input  logic [AW-1:0] lbase,
    input  logic [15:0]   llimit,
    output logic [AW-1:0] desc_addr,
    output logic          lim_fault
);
    logic [12:0] idx;
    logic        ti;
    logic [15:0] last_byte;

    always_comb begin
        idx       = sel[15:3];
        ti        = sel[2];
        last_byte = {idx, 3'b111};
        desc_addr = (ti ? lbase : gbase) + {{(AW-16){1'b0}}, idx, 3'b000};
        lim_fault = last_byte > (ti ? llimit : glimit);
    end
endmodule

// File: rtl/seg_cache.sv
module seg_cache
    import seg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [RW-1:0]     wr_idx,
    input  desc_t             wr_desc,
    input  logic [SW-1:0]     wr_sel,
    input  logic [RW-1:0]     rd_idx,
    output desc_t             rd_desc,
    output logic [SW-1:0]     rd_sel,
    output logic              rd_valid,
    input  logic [RW-1:0]     tr_idx,
    output logic [AW-1:0]     tr_base,
    output logic              tr_valid,
    output logic [NUM_SEG-1:0] valid_vec
);
    desc_t         desc_q [NUM_SEG];
    logic [SW-1:0] sel_q  [NUM_SEG];

    for (genvar i = 0; i < NUM_SEG; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_vec[i] <= 1'b0;
                desc_q[i]    <= '0;
                sel_q[i]     <= '0;
            end else if (wr_en && wr_idx == RW'(i)) begin
                valid_vec[i] <= 1'b1;
                desc_q[i]    <= wr_desc;
                sel_q[i]     <= wr_sel;
            end
        end
    end

    always_comb begin
        rd_desc  = '0;
        rd_sel   = '0;
        rd_valid = 1'b0;
        tr_base  = '0;
        tr_valid = 1'b0;
        if (int'(rd_idx) < NUM_SEG) begin
            rd_desc  = desc_q[rd_idx];
            rd_sel   = sel_q[rd_idx];
            rd_valid = valid_vec[rd_idx];
        end
        if (int'(tr_idx) < NUM_SEG) begin
            tr_base  = desc_q[tr_idx].base;
            tr_valid = valid_vec[tr_idx];
        end
    end

    // R9
    wr_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_idx) < NUM_SEG));
endmodule

// File: rtl/seg_loader.sv
module seg_loader
    import seg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tbl_we,
    input  logic          tbl_sel,
    input  logic [31:0]   tbl_base,
    input  logic [15:0]   tbl_limit,
    input  logic          ld_req,
    input  logic [2:0]    ld_reg,
    input  logic [15:0]   ld_sel,
    output logic          busy,
    output logic          done,
    output logic          fault,
    output logic [1:0]    fault_code,
    output logic          mem_req,
    output logic [31:0]   mem_addr,
    input  logic          mem_rvalid,
    input  logic [31:0]   mem_rdata,
    input  logic [2:0]    rd_reg,
    output logic          rd_valid,
    output logic [31:0]   rd_base,
    output logic [19:0]   rd_limit,
    output logic          rd_gran,
    output logic          rd_db,
    output logic          rd_avl,
    output logic          rd_sys,
    output logic [3:0]    rd_type,
    output logic [1:0]    rd_dpl,
    output logic [15:0]   rd_selector,
    output logic [1:0]    cpl,
    input  logic [2:0]    tr_reg,
    input  logic [31:0]   tr_off,
    output logic [31:0]   tr_lin,
    output logic          tr_fault
);
    ld_state_e     state;
    flt_e          flt;
    logic [RW-1:0] cur_reg;
    logic [SW-1:0] cur_sel;
    logic [AW-1:0] cur_addr;
    logic [31:0]   lo_word;
    logic [31:0]   hi_word;
    logic [AW-1:0] gbase, lbase;
    logic [15:0]   glimit, llimit;
    logic [AW-1:0] dec_addr;
    logic          dec_lim_fault;
    logic          present;
    logic          cache_we;
    desc_t         new_desc;
    desc_t         rd_desc;
    logic [AW-1:0] tr_base;
    logic          tr_valid;
    logic [NUM_SEG-1:0] valid_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            gbase <= '0; glimit <= '0; lbase <= '0; llimit <= '0;
        end else if (tbl_we) begin
            if (tbl_sel) begin
                lbase <= tbl_base; llimit <= tbl_limit;
            end else begin
                gbase <= tbl_base; glimit <= tbl_limit;
            end
        end
    end

    seg_sel_decode u_dec (
        .sel(ld_sel), .gbase(gbase), .glimit(glimit),
        .lbase(lbase), .llimit(llimit),
        .desc_addr(dec_addr), .lim_fault(dec_lim_fault)
    );

    always_comb begin
        new_desc = unpack_desc({hi_word, lo_word});
        present  = hi_word[15];
        cache_we = (state == ST_CHECK) && present;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            flt      <= FLT_NONE;
            cpl      <= 2'd0;
            cur_reg  <= '0;
            cur_sel  <= '0;
            cur_addr <= '0;
            lo_word  <= '0;
            hi_word  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (ld_req && int'(ld_reg) < NUM_SEG) begin
                        cur_reg  <= ld_reg;
                        cur_sel  <= ld_sel;
                        cur_addr <= dec_addr;
                        if (dec_lim_fault) begin
                            flt   <= FLT_LIMIT;
                            state <= ST_DONE;
                        end else begin
                            flt   <= FLT_NONE;
                            state <= ST_FETCH_LO;
                        end
                    end
                end
                ST_FETCH_LO: if (mem_rvalid) begin
                    lo_word <= mem_rdata;
                    state   <= ST_FETCH_HI;
                end
                ST_FETCH_HI: if (mem_rvalid) begin
                    hi_word <= mem_rdata;
                    state   <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (!present) flt <= FLT_ABSENT;
                    else if (int'(cur_reg) == CS_IDX) cpl <= cur_sel[1:0];
                    state <= ST_DONE;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    seg_cache u_cache (
        .clk(clk), .rst(rst),
        .wr_en(cache_we), .wr_idx(cur_reg), .wr_desc(new_desc), .wr_sel(cur_sel),
        .rd_idx(rd_reg), .rd_desc(rd_desc), .rd_sel(rd_selector), .rd_valid(rd_valid),
        .tr_idx(tr_reg), .tr_base(tr_base), .tr_valid(tr_valid),
        .valid_vec(valid_vec)
    );

    always_comb begin
        busy       = (state != ST_IDLE);
        done       = (state == ST_DONE);
        fault      = done && (flt != FLT_NONE);
        fault_code = done ? flt : FLT_NONE;
        mem_req    = (state == ST_FETCH_LO) || (state == ST_FETCH_HI);
        mem_addr   = cur_addr + ((state == ST_FETCH_HI) ? 32'd4 : 32'd0);
        rd_base    = rd_desc.base;
        rd_limit   = rd_desc.limit;
        rd_gran    = rd_desc.gran;
        rd_db      = rd_desc.db;
        rd_avl     = rd_desc.avl;
        rd_sys     = rd_desc.sys;
        rd_type    = rd_desc.stype;
        rd_dpl     = rd_desc.dpl;
        tr_lin     = tr_base + tr_off;
        tr_fault   = !tr_valid;
    end

    // R2
    beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);
    // R4
    fault_keeps_cache_chk: assert property (@(posedge clk) disable iff (rst)
        fault |-> $stable(valid_vec));
    // R6
    cpl_change_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cpl) |-> (done && !fault));
    // R5
    limit_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        (done && fault_code == FLT_LIMIT) |-> $past(!mem_req));
endmodule

// File: tb/seg_loader_test.sv
module seg_loader_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        tbl_we = 0, tbl_sel = 0;
    logic [31:0] tbl_base = 0;
    logic [15:0] tbl_limit = 0;
    logic        ld_req = 0;
    logic [2:0]  ld_reg = 0;
    logic [15:0] ld_sel = 0;
    logic        busy, done, fault;
    logic [1:0]  fault_code;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 0;
    logic [31:0] mem_rdata = 0;
    logic [2:0]  rd_reg = 0;
    logic        rd_valid, rd_gran, rd_db, rd_avl, rd_sys;
    logic [31:0] rd_base;
    logic [19:0] rd_limit;
    logic [3:0]  rd_type;
    logic [1:0]  rd_dpl, cpl;
    logic [15:0] rd_selector;
    logic [2:0]  tr_reg = 0;
    logic [31:0] tr_off = 0;
    logic [31:0] tr_lin;
    logic        tr_fault;

    seg_loader uut (.*);

    always #10 clk = ~clk;

    localparam logic [31:0] GB = 32'h0000_1000, LB = 32'h0000_8000;
    localparam int GN = 16, LN = 8;

    logic [63:0] gdt [GN];
    logic [63:0] ldt [LN];
    logic        m_valid [6];
    logic [63:0] m_desc  [6];
    logic [15:0] m_sel   [6];
    logic [1:0]  m_cpl;
    logic [31:0] log_addr [4];
    int          nlog;
    int          wait_cnt;
    int          errors = 0, checks = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_at(input logic [31:0] a);
        if (a >= GB && a < GB + GN*8) begin
            logic [63:0] d = gdt[(a - GB) >> 3];
            return a[2] ? d[63:32] : d[31:0];
        end
        if (a >= LB && a < LB + LN*8) begin
            logic [63:0] d = ldt[(a - LB) >> 3];
            return a[2] ? d[63:32] : d[31:0];
        end
        return 32'hDEAD_BEEF;
    endfunction

    function automatic logic [31:0] f_base(input logic [63:0] d);
        return {d[63:56], d[39:32], d[31:16]};
    endfunction
    function automatic logic [19:0] f_limit(input logic [63:0] d);
        return {d[51:48], d[15:0]};
    endfunction

    // read port responder
    initial begin
        wait_cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_req && wait_cnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = word_at(mem_addr);
                if (nlog < 4) log_addr[nlog] = mem_addr;
                nlog++;
                wait_cnt = $urandom % 3;
            end else begin
                mem_rvalid = 1'b0;
                if (mem_req && wait_cnt > 0) wait_cnt--;
            end
        end
    end

    task automatic check_reg(input int r);
        rd_reg = 3'(r);
        #1;
        chk(rd_valid == m_valid[r], "R3 valid", 64'(rd_valid), 64'(m_valid[r]));
        if (m_valid[r]) begin
            logic [63:0] d = m_desc[r];
            chk(rd_base == f_base(d), "R3 base", 64'(rd_base), 64'(f_base(d)));
            chk(rd_limit == f_limit(d), "R3 limit", 64'(rd_limit), 64'(f_limit(d)));
            chk({rd_gran, rd_db, rd_avl, rd_sys} == {d[55], d[54], d[52], d[44]},
                "R3 flags", 64'({rd_gran, rd_db, rd_avl, rd_sys}), 64'({d[55], d[54], d[52], d[44]}));
            chk({rd_type, rd_dpl} == {d[43:40], d[46:45]}, "R3 type/dpl",
                64'({rd_type, rd_dpl}), 64'({d[43:40], d[46:45]}));
            chk(rd_selector == m_sel[r], "R11 selector", 64'(rd_selector), 64'(m_sel[r]));
        end
        tr_reg = 3'(r);
        tr_off = $urandom;
        #1;
        chk(tr_fault == !m_valid[r], "R7 tr_fault", 64'(tr_fault), 64'(!m_valid[r]));
        if (m_valid[r])
            chk(tr_lin == f_base(m_desc[r]) + tr_off, "R8 tr_lin", 64'(tr_lin),
                64'(f_base(m_desc[r]) + tr_off));
        chk(!mem_req, "R8 idle no request", 64'(mem_req), 64'(0));
    endtask

    task automatic do_load(input int r, input logic [15:0] s, input bit intrude);
        logic [12:0] idx = s[15:3];
        logic        ti  = s[2];
        logic [31:0] base = ti ? LB : GB;
        int          lim = ti ? LN*8-1 : GN*8-1;
        int          exp_code;
        logic [63:0] d;
        int          n;
        logic [1:0]  prev_cpl;
        @(negedge clk);
        nlog = 0;
        ld_req = 1; ld_reg = 3'(r); ld_sel = s;
        @(negedge clk);
        ld_req = 0;
        chk(busy, "R9 busy after request", 64'(busy), 64'(1));
        if (intrude) begin
            prev_cpl = m_cpl;
            ld_req = 1; ld_reg = 3'd5; ld_sel = 16'h0008;
            @(negedge clk);
            ld_req = 0;
        end
        n = 0;
        while (!done && n < 50) begin @(negedge clk); n++; end
        if ((int'(idx) * 8 + 7) > lim) exp_code = 1;
        else begin
            d = ti ? ldt[idx] : gdt[idx];
            exp_code = d[47] ? 0 : 2;
        end
        chk(done, "R9 done seen", 64'(done), 64'(1));
        chk(fault_code == 2'(exp_code), exp_code == 1 ? "R5 code" : "R4 code",
            64'(fault_code), 64'(exp_code));
        chk(fault == (exp_code != 0), "R4 fault flag", 64'(fault), 64'(exp_code != 0));
        if (exp_code == 1) chk(nlog == 0, "R5 no read", 64'(nlog), 64'(0));
        else begin
            chk(nlog == 2, "R1 two beats", 64'(nlog), 64'(2));
            chk(log_addr[0] == base + 32'(idx) * 8, "R1 first address", 64'(log_addr[0]),
                64'(base + 32'(idx) * 8));
            chk(log_addr[1] == base + 32'(idx) * 8 + 4, "R1 second address", 64'(log_addr[1]),
                64'(base + 32'(idx) * 8 + 4));
        end
        if (exp_code == 0) begin
            m_valid[r] = 1; m_desc[r] = d; m_sel[r] = s;
            if (r == 1) m_cpl = s[1:0];
        end
        chk(cpl == m_cpl, "R6 cpl", 64'(cpl), 64'(m_cpl));
        @(negedge clk);
        chk(!done && !busy, "R9 single done pulse", 64'({done, busy}), 64'(0));
        check_reg(r);
        if (intrude) check_reg(5);
    endtask

    task automatic write_tbl(input bit sel, input logic [31:0] b, input logic [15:0] l);
        @(negedge clk);
        tbl_we = 1; tbl_sel = sel; tbl_base = b; tbl_limit = l;
        @(negedge clk);
        tbl_we = 0;
    endtask

    function automatic logic [63:0] rand_desc(input bit pres);
        logic [63:0] d = {$urandom, $urandom};
        d[47] = pres;
        return d;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < GN; i++) gdt[i] = rand_desc(($urandom % 4) != 0);
        for (int i = 0; i < LN; i++) ldt[i] = rand_desc(($urandom % 4) != 0);
        for (int i = 0; i < 6; i++) begin m_valid[i] = 0; m_desc[i] = 0; m_sel[i] = 0; end
        m_cpl = 0;
        rst = 1;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R7 reset state
        chk(!busy && !done && cpl == 0, "R7 reset idle", 64'({busy, done, cpl}), 64'(0));
        for (int r = 0; r < 6; r++) check_reg(r);

        // R10 table writes
        write_tbl(0, GB, 16'(GN*8-1));
        write_tbl(1, LB, 16'(LN*8-1));

        // directed: last global entry, one past it, present and absent
        gdt[15][47] = 1; gdt[3][47] = 0; ldt[2][47] = 1; gdt[4][47] = 1;
        do_load(2, {13'd15, 1'b0, 2'd0}, 0);
        do_load(2, {13'd16, 1'b0, 2'd0}, 0);      // R5 boundary
        do_load(3, {13'd8, 1'b1, 2'd1}, 0);       // R5 local boundary
        do_load(3, {13'd3, 1'b0, 2'd2}, 0);       // R4 absent
        do_load(1, {13'd2, 1'b1, 2'd3}, 0);       // R6 CS sets cpl
        do_load(3, {13'd4, 1'b0, 2'd1}, 1);       // R9 request while busy ignored
        do_load(1, {13'd3, 1'b0, 2'd0}, 0);       // R6 faulting CS keeps cpl

        // R9 out of range register ignored
        @(negedge clk);
        ld_req = 1; ld_reg = 3'd6; ld_sel = 16'h0008;
        @(negedge clk);
        ld_req = 0;
        chk(!busy, "R9 reg 6 ignored", 64'(busy), 64'(0));

        for (int k = 0; k < 80; k++) begin
            bit ti = $urandom % 2;
            int ix = ti ? ($urandom % (LN + 2)) : ($urandom % (GN + 2));
            do_load($urandom % 6, {13'(ix), ti, 2'($urandom % 4)}, 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule